// File: doc/BRIEF.md
# Priority Message Receive Extractor

This block sits after the lane deframer and watches the stream of decoded blocks, one block per clock. It picks out the blocks that belong to short, high-priority user messages and presents their payload on a dedicated stream output with valid, last and a byte-keep mask. A message starts with a header block that carries its size. One or more message data blocks follow. Control, clock-compensation, idle and regular data blocks may be interleaved between them.

The block counts the message bytes using the size from the header. It drops interleaved control and idle blocks without producing beats. On the final beat it derives the keep mask from the remaining byte count, not from the payload. Regular data blocks go to a separate output unchanged, even while a message is open. An active-low status output shows when a message is being received.

All outputs are registered and appear one clock after the block that causes them. The bus is 64×N bits wide for N lanes, so a beat holds 8×N bytes.

Top module: `msg_rx_extractor`

## Requirements
- R1: While rst_ni is low and in the first cycle after its release, msg_valid_o and reg_valid_o are low and msg_busy_no is high.
- R2: A valid block of kind 2 (message header) loads the byte count from blk_data_i[7:0] plus one (0 means 1 byte, 255 means 256 bytes). It produces no output beat, and msg_busy_no is low from the next cycle.
- R3: While a message is open, each valid block of kind 3 (message data) produces exactly one beat on the next cycle, with msg_data_o equal to blk_data_i.
- R4: msg_last_o is high only on the beat that completes the byte count from the header, that is, on beat ceil((size+1)/(8×N)).
- R5: On the last beat, msg_keep_o has its top r bits set and the rest clear, where r is the number of remaining bytes. Bit 8N-1 is the leftmost byte, blk_data_i[64N-1:64N-8]. On every other beat all keep bits are set.
- R6: Blocks of kind 0 (idle), 4 (control) or 5 (clock compensation), other unused kinds, and cycles with blk_valid_i low produce no message beat and do not change the remaining count.
- R7: A valid block of kind 1 (regular data) appears on reg_data_o with reg_valid_o high on the next cycle, unchanged, whether or not a message is open.
- R8: msg_busy_no goes high in the same cycle as the last beat of a message.
- R9: A message data block that arrives while no message is open is dropped and produces no beat.
- R10: A header that arrives while a message is open abandons that message and restarts the count with the new size.
- R11: The largest message, 256 bytes, completes with all its beats and the count never exceeds 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | Decoded block present this cycle |
| blk_kind_i | input | 3 | Block kind code |
| blk_data_i | input | 64N | Block payload |
| msg_data_o | output | 64N | Message payload beat |
| msg_valid_o | output | 1 | Message beat valid |
| msg_last_o | output | 1 | Final beat of message |
| msg_keep_o | output | 8N | Byte-valid mask, meaningful with last |
| msg_busy_no | output | 1 | Low while a message is being received |
| reg_data_o | output | 64N | Forwarded regular data |
| reg_valid_o | output | 1 | Forwarded regular data valid |

## Verification
The assertions check on every cycle that:
- a message beat follows a cycle with a message open;
- the status returns high on every last beat;
- the keep mask is a nonzero run of bits starting from the leftmost byte;
- regular data is a one-cycle copy of the input;
- the counter never passes 256.

Only the bench's scenarios can show that:
- the beat count matches the header size across sizes 1, 8, 9 and 256;
- interleaved control and idle blocks leave the count untouched;
- orphan data is dropped;
- a second header restarts the count.

// File: rtl/msg_rx_pkg.sv
package msg_rx_pkg;
  typedef enum logic [2:0] {
    BLK_IDLE  = 3'd0,
    BLK_DATA  = 3'd1,
    BLK_HDR   = 3'd2,
    BLK_MSG   = 3'd3,
    BLK_CTRL  = 3'd4,
    BLK_CCOMP = 3'd5
  } blk_kind_e;
endpackage

// File: rtl/msg_keep_gen.sv
module msg_keep_gen #(
  parameter int BYTES = 8,
  parameter int CNT_W = 9
) (
  input  logic [CNT_W-1:0] rem_i,
  output logic [BYTES-1:0] mask_o
);
  // leftmost byte is the msb lane
  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign mask_o[i] = rem_i > CNT_W'(BYTES - 1 - i);
  end
endmodule

// File: rtl/msg_byte_tracker.sv
module msg_byte_tracker #(
  parameter int BYTES     = 8,
  parameter int MAX_BYTES = 256,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int SIZE_W   = $clog2(MAX_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_i,
  input  logic              dat_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic              busy_o,
  output logic              beat_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  rem_o
);
  logic             busy_q;
  logic [CNT_W-1:0] rem_q;

  assign beat_o = dat_i && busy_q;
  assign last_o = beat_o && (rem_q <= CNT_W'(BYTES));
  assign busy_o = busy_q;
  assign rem_o  = rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      rem_q  <= '0;
    end else if (hdr_i) begin
      busy_q <= 1'b1;
      rem_q  <= CNT_W'(size_i) + CNT_W'(1);
    end else if (beat_o) begin
      if (last_o) begin
        busy_q <= 1'b0;
        rem_q  <= '0;
      end else begin
        rem_q  <= rem_q - CNT_W'(BYTES);
      end
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= CNT_W'(MAX_BYTES));
  p_hold_count_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hdr_i && !dat_i) |=> $stable(rem_q));
  p_open_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q != '0);
endmodule

// File: rtl/msg_rx_extractor.sv
module msg_rx_extractor
  import msg_rx_pkg::*;
#(
  parameter int LANES     = 1,
  parameter int MAX_BYTES = 256,
  localparam int BYTES    = 8 * LANES,
  localparam int W        = 64 * LANES,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int SIZE_W   = $clog2(MAX_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_valid_i,
  input  logic [2:0]       blk_kind_i,
  input  logic [W-1:0]     blk_data_i,
  output logic [W-1:0]     msg_data_o,
  output logic             msg_valid_o,
  output logic             msg_last_o,
  output logic [BYTES-1:0] msg_keep_o,
  output logic             msg_busy_no,
  output logic [W-1:0]     reg_data_o,
  output logic             reg_valid_o
);
  logic             is_hdr, is_msg, is_reg;
  logic             busy, beat, last;
  logic [CNT_W-1:0] rem;
  logic [BYTES-1:0] tail_mask;

  assign is_hdr = blk_valid_i && (blk_kind_i == BLK_HDR);
  assign is_msg = blk_valid_i && (blk_kind_i == BLK_MSG);
  assign is_reg = blk_valid_i && (blk_kind_i == BLK_DATA);

  msg_byte_tracker #(.BYTES(BYTES), .MAX_BYTES(MAX_BYTES)) i_tracker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hdr_i  (is_hdr),
    .dat_i  (is_msg),
    .size_i (blk_data_i[SIZE_W-1:0]),
    .busy_o (busy),
    .beat_o (beat),
    .last_o (last),
    .rem_o  (rem)
  );

  msg_keep_gen #(.BYTES(BYTES), .CNT_W(CNT_W)) i_keep (
    .rem_i  (rem),
    .mask_o (tail_mask)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_last_o  <= 1'b0;
      msg_keep_o  <= '0;
      msg_data_o  <= '0;
      reg_valid_o <= 1'b0;
      reg_data_o  <= '0;
    end else begin
      msg_valid_o <= beat;
      msg_last_o  <= last;
      reg_valid_o <= is_reg;
      if (beat) begin
        msg_data_o <= blk_data_i;
        msg_keep_o <= last ? tail_mask : '1;
      end
      if (is_reg) reg_data_o <= blk_data_i;
    end
  end

  assign msg_busy_no = ~busy;

  p_beat_needs_open_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !$past(msg_busy_no));
  p_last_closes_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_last_o |-> (msg_valid_o && msg_busy_no));
  p_keep_left_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_last_o |-> (msg_keep_o != '0 && ((~msg_keep_o) & ((~msg_keep_o) + 1'b1)) == '0));
  p_reg_copy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_valid_o |-> ($past(blk_valid_i) && $past(blk_kind_i) == BLK_DATA
                     && reg_data_o == $past(blk_data_i)));
endmodule

// File: tb/test_msg_rx_extractor.sv
`timescale 1ns/1ps
module test_msg_rx_extractor;
  localparam int BYTES = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        blk_valid_i = 1'b0;
  logic [2:0]  blk_kind_i = 3'd0;
  logic [63:0] blk_data_i = '0;
  logic [63:0] msg_data_o, reg_data_o;
  logic        msg_valid_o, msg_last_o, msg_busy_no, reg_valid_o;
  logic [7:0]  msg_keep_o;

  int checks = 0;
  int errors = 0;
  bit m_busy = 0;
  int m_rem = 0;

  always #2.5 clk = ~clk;

  msg_rx_extractor #(.LANES(1)) i_msg_rx_extractor (
    .clk_i(clk), .rst_ni(rst_ni), .blk_valid_i(blk_valid_i), .blk_kind_i(blk_kind_i),
    .blk_data_i(blk_data_i), .msg_data_o(msg_data_o), .msg_valid_o(msg_valid_o),
    .msg_last_o(msg_last_o), .msg_keep_o(msg_keep_o), .msg_busy_no(msg_busy_no),
    .reg_data_o(reg_data_o), .reg_valid_o(reg_valid_o)
  );

  function automatic logic [7:0] exp_keep(int r);
    logic [7:0] k = '0;
    for (int i = 0; i < BYTES; i++) if (i < r) k[BYTES-1-i] = 1'b1;
    return k;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(bit v, logic [2:0] k, logic [63:0] d, string tag);
    bit e_mv, e_ml, e_rv;
    logic [7:0] e_keep;
    @(negedge clk);
    blk_valid_i = v; blk_kind_i = k; blk_data_i = d;
    e_mv = 0; e_ml = 0; e_keep = '1;
    e_rv = v && k == 3'd1;
    if (v && k == 3'd2) begin
      m_busy = 1; m_rem = int'(d[7:0]) + 1;
    end else if (v && k == 3'd3 && m_busy) begin
      e_mv = 1;
      if (m_rem <= BYTES) begin
        e_ml = 1; e_keep = exp_keep(m_rem); m_busy = 0; m_rem = 0;
      end else m_rem -= BYTES;
    end
    @(posedge clk); #1;
    check(msg_valid_o == e_mv, {tag, " R3/R6/R9 valid"}, 64'(msg_valid_o), 64'(e_mv));
    check(msg_busy_no == !m_busy, {tag, " R2/R8 busy_n"}, 64'(msg_busy_no), 64'(!m_busy));
    check(reg_valid_o == e_rv, {tag, " R7 reg valid"}, 64'(reg_valid_o), 64'(e_rv));
    if (e_rv) check(reg_data_o == d, {tag, " R7 reg data"}, reg_data_o, d);
    if (e_mv) begin
      check(msg_data_o == d, {tag, " R3 data"}, msg_data_o, d);
      check(msg_last_o == e_ml, {tag, " R4 last"}, 64'(msg_last_o), 64'(e_ml));
      if (e_ml) check(msg_keep_o == e_keep, {tag, " R5 keep"}, 64'(msg_keep_o), 64'(e_keep));
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic send_msg(int size, int noise, string tag);
    int beats = (size + 1 + BYTES - 1) / BYTES;
    step(1, 3'd2, {rnd64() & 64'hFFFF_FFFF_FFFF_FF00} | 64'(size), {tag, " R2 hdr"});
    for (int b = 0; b < beats; b++) begin
      for (int j = 0; j < noise; j++) begin
        int pick = $urandom % 6;
        case (pick)
          0: step(1, 3'd0, rnd64(), {tag, " R6 idle"});
          1: step(1, 3'd4, rnd64(), {tag, " R6 ctrl"});
          2: step(1, 3'd5, rnd64(), {tag, " R6 ccomp"});
          3: step(0, 3'd3, rnd64(), {tag, " R6 invalid"});
          4: step(1, 3'd7, rnd64(), {tag, " R6 unused"});
          default: step(1, 3'd1, rnd64(), {tag, " R7 reg mid"});
        endcase
      end
      step(1, 3'd3, rnd64(), {tag, " R4 beat"});
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    #1;
    check(msg_valid_o == 0 && reg_valid_o == 0 && msg_busy_no == 1, "R1 reset",
          {61'd0, msg_valid_o, reg_valid_o, msg_busy_no}, 64'd1);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    @(posedge clk); #1;
    check(msg_valid_o == 0 && reg_valid_o == 0 && msg_busy_no == 1, "R1 after release",
          {61'd0, msg_valid_o, reg_valid_o, msg_busy_no}, 64'd1);
    step(1, 3'd3, 64'hDEAD_BEEF_0000_0001, "R9 orphan");
    step(1, 3'd1, 64'h0123_4567_89AB_CDEF, "R7 idle-time reg");
    send_msg(0, 0, "R5 one byte");
    send_msg(7, 0, "R4 exact beat");
    send_msg(8, 1, "R4 nine bytes");
    send_msg(255, 0, "R11 max");
    // R10: restart with a second header mid-message
    step(1, 3'd2, 64'd40, "R10 hdr1");
    step(1, 3'd3, rnd64(), "R10 beat");
    send_msg(2, 0, "R10 restart");
    step(1, 3'd3, rnd64(), "R9 after close");
    for (int n = 0; n < 60; n++) send_msg($urandom % 256, $urandom % 3, "rand");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule